// File: doc/BRIEF.md
# Vector Start-Index Trap Decision Unit

This block sits beside the vector decode stage. For each decoded vector instruction it decides whether the current start-index CSR value (the element at which execution resumes) has to raise an illegal-instruction trap. It also encodes why the trap is raised. The decoder supplies a small policy-class tag together with the start index. It also supplies the total element count the instruction spans, which already includes the register-group multiplier, and the base-2 logarithm of the element-group size. The decision is combinational. The trap strobe and the reason code are valid in the same cycle as the decode-valid input, and both are zero whenever decode-valid is low.

Each policy class handles a non-zero start index in its own way. Memory-access instructions never trap on it, because the start index is how a faulted access resumes. Ordinary arithmetic instructions trap only when the arithmetic enable bit is set. This class also covers element-wise bit-manipulation crypto, carry-less multiply, absolute difference and bfloat16 operations. Scalar-move instructions (element 0 to a scalar register and back, in integer and floating-point forms) follow their own enable bit. Reductions, compress, mask population count, find-first-set, the three set-before/including/only-first forms and iota always trap. Element-group crypto instructions trap only when the start index is not a multiple of the group size.

The two enable bits are kept in a small register inside the block. Both bits reset to 1, which means trapping is the default. A write strobe loads new values, and they take effect from the cycle after the write edge. Two further checks apply on top of the class policies: a start index at or beyond the element count, and a start index that is not group-aligned.

Top module: `vstart_trap_chk`

## Requirements
- R1: `trap_code` encodes the reason: 2'b00 no trap, 2'b01 class policy, 2'b10 start index out of bounds, 2'b11 element-group misalignment. `trap_req` is 1 exactly when `trap_code` is non-zero.
- R2: When `vstart` is zero, no trap is raised, whatever the class, the enable bits, the element count or the group size.
- R3: Class code 3'd1 (memory access) never gives a policy trap.
- R4: Class code 3'd0 (arithmetic) with a non-zero `vstart` gives a policy trap only while the arithmetic enable bit is 1. That bit resets to 1. It is loaded from `cfg_arith_in` on a clock edge where `cfg_we` is 1, and the new value applies from then on.
- R5: Class code 3'd2 (scalar move) with a non-zero `vstart` gives a policy trap only while the scalar-move enable bit is 1. That bit resets to 1 and is loaded from `cfg_smove_in` in the same way.
- R6: Class code 3'd3 (always-trap) with a non-zero `vstart` gives a policy trap regardless of the enable bits. The reserved codes 3'd5 to 3'd7 are treated the same way.
- R7: Class code 3'd4 (element group) never gives a policy trap.
- R8: Misalignment is reported when `vstart` modulo 2^`egs_log2` is non-zero. A value of 0 for `egs_log2` means the start index is always aligned.
- R9: Out-of-bounds is reported when `vstart` is greater than or equal to `elem_cnt`, the full grouped element count, so an index past one register's worth is legal when `elem_cnt` is larger.
- R10: When several reasons hold at once, misalignment wins over out-of-bounds, and out-of-bounds wins over policy.
- R11: While `dec_valid` is 0, `trap_req` and `trap_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the enable bits |
| cfg_arith_in | input | 1 | New arithmetic enable bit |
| cfg_smove_in | input | 1 | New scalar-move enable bit |
| dec_valid | input | 1 | Decoded instruction present |
| dec_class | input | 3 | Policy class tag |
| vstart | input | VSTART_W | Current start-index value |
| elem_cnt | input | VSTART_W+1 | Full element count of the instruction |
| egs_log2 | input | EGS_LOG_W | Base-2 log of the element-group size |
| trap_req | output | 1 | Trap request strobe |
| trap_code | output | 2 | Trap reason code |

## Verification
Three of the block's functions can hold in the same cycle: the policy trap, the bounds check and the alignment check. A case where only one of them applies cannot show whether the priority order is right. The vector table therefore includes inputs where two or all three hold together. One example is an always-trap instruction at exactly the element count. Another is a group instruction that is both misaligned and past its count. For each case the code is judged against the highest-priority reason alone. The enable-register write is a second overlap: it is made in the same cycle as an arithmetic decode. The bench checks that the old bit still governs that cycle and the new bit governs the next one.

// File: rtl/vstart_trap_pkg.sv
package vstart_trap_pkg;

    typedef enum logic [2:0] {
        CLS_ARITH     = 3'd0,
        CLS_MEMORY    = 3'd1,
        CLS_SCALAR_MV = 3'd2,
        CLS_ALWAYS    = 3'd3,
        CLS_GROUP     = 3'd4
    } vclass_e;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'b00,
        RSN_POLICY = 2'b01,
        RSN_BOUNDS = 2'b10,
        RSN_ALIGN  = 2'b11
    } reason_e;

endpackage

// File: rtl/vstart_cfg_reg.sv
module vstart_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_arith_in,
    input  logic cfg_smove_in,
    output logic arith_en,
    output logic smove_en
);

    // Both enables come out of reset set, so trapping is the default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arith_en <= 1'b1;
            smove_en <= 1'b1;
        end else if (cfg_we) begin
            arith_en <= cfg_arith_in;
            smove_en <= cfg_smove_in;
        end
    end

endmodule

// File: rtl/vstart_policy.sv
module vstart_policy
    import vstart_trap_pkg::*;
(
    input  logic [2:0] cls,
    input  logic       arith_en,
    input  logic       smove_en,
    output logic       policy_hit
);

    // Result assumes the start index is non-zero; the top gates on that.
    always_comb begin
        unique case (cls)
            CLS_ARITH:     policy_hit = arith_en;
            CLS_MEMORY:    policy_hit = 1'b0;
            CLS_SCALAR_MV: policy_hit = smove_en;
            CLS_ALWAYS:    policy_hit = 1'b1;
            CLS_GROUP:     policy_hit = 1'b0;
            default:       policy_hit = 1'b1;   // reserved tags: safest choice
        endcase
    end

endmodule

// File: rtl/vstart_bounds.sv
module vstart_bounds #(
    parameter int VSTART_W  = 16,
    parameter int EGS_LOG_W = 3,
    parameter int CNT_W     = VSTART_W + 1
) (
    input  logic [VSTART_W-1:0]  vstart,
    input  logic [CNT_W-1:0]     elem_cnt,
    input  logic [EGS_LOG_W-1:0] egs_log2,
    output logic                 out_of_bounds,
    output logic                 misaligned
);

    logic [CNT_W-1:0]    vstart_ext;
    logic [VSTART_W-1:0] grp_mask;

    always_comb begin
        vstart_ext    = CNT_W'(vstart);
        out_of_bounds = (vstart_ext >= elem_cnt);
        grp_mask      = (VSTART_W'(1) << egs_log2) - VSTART_W'(1);
        misaligned    = |(vstart & grp_mask);
    end

endmodule

// File: rtl/vstart_trap_chk.sv
module vstart_trap_chk
    import vstart_trap_pkg::*;
#(
    parameter  int VSTART_W  = 16,
    parameter  int EGS_LOG_W = 3,
    localparam int CNT_W     = VSTART_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_arith_in,
    input  logic                 cfg_smove_in,
    input  logic                 dec_valid,
    input  logic [2:0]           dec_class,
    input  logic [VSTART_W-1:0]  vstart,
    input  logic [CNT_W-1:0]     elem_cnt,
    input  logic [EGS_LOG_W-1:0] egs_log2,
    output logic                 trap_req,
    output logic [1:0]           trap_code
);

    logic arith_en;
    logic smove_en;
    logic policy_hit;
    logic out_of_bounds;
    logic misaligned;
    logic active;
    reason_e reason;

    vstart_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_arith_in (cfg_arith_in),
        .cfg_smove_in (cfg_smove_in),
        .arith_en     (arith_en),
        .smove_en     (smove_en)
    );

    vstart_policy u_policy (
        .cls        (dec_class),
        .arith_en   (arith_en),
        .smove_en   (smove_en),
        .policy_hit (policy_hit)
    );

    vstart_bounds #(
        .VSTART_W  (VSTART_W),
        .EGS_LOG_W (EGS_LOG_W),
        .CNT_W     (CNT_W)
    ) u_bounds (
        .vstart        (vstart),
        .elem_cnt      (elem_cnt),
        .egs_log2      (egs_log2),
        .out_of_bounds (out_of_bounds),
        .misaligned    (misaligned)
    );

    // A zero start index is always legal, so everything is gated on it.
    assign active = dec_valid && (vstart != '0);

    always_comb begin
        if (!active)            reason = RSN_NONE;
        else if (misaligned)    reason = RSN_ALIGN;
        else if (out_of_bounds) reason = RSN_BOUNDS;
        else if (policy_hit)    reason = RSN_POLICY;
        else                    reason = RSN_NONE;
    end

    assign trap_code = reason;
    assign trap_req  = (reason != RSN_NONE);

endmodule

// File: rtl/vstart_trap_chk_sva.sv
module vstart_trap_chk_sva #(
    parameter int VSTART_W  = 16,
    parameter int EGS_LOG_W = 3,
    parameter int CNT_W     = VSTART_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dec_valid,
    input logic [2:0]           dec_class,
    input logic [VSTART_W-1:0]  vstart,
    input logic [CNT_W-1:0]     elem_cnt,
    input logic [EGS_LOG_W-1:0] egs_log2,
    input logic                 trap_req,
    input logic [1:0]           trap_code
);

    a_r1_strobe_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req == (trap_code != 2'b00));

    a_r2_zero_start_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (vstart == '0) |-> (trap_code == 2'b00));

    a_r3_memory_no_policy: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd1) |-> (trap_code != 2'b01));

    a_r6_always_class_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd3 && vstart != '0) |-> trap_req);

    a_r7_group_no_policy: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == 3'd4) |-> (trap_code != 2'b01));

    a_r9_past_count_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && vstart != '0 && CNT_W'(vstart) >= elem_cnt) |-> (trap_code[1] == 1'b1));

    a_r8_zero_log_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (egs_log2 == '0) |-> (trap_code != 2'b11));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!trap_req && trap_code == 2'b00));

endmodule

bind vstart_trap_chk vstart_trap_chk_sva #(
    .VSTART_W  (VSTART_W),
    .EGS_LOG_W (EGS_LOG_W),
    .CNT_W     (CNT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_class (dec_class),
    .vstart    (vstart),
    .elem_cnt  (elem_cnt),
    .egs_log2  (egs_log2),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/vstart_trap_chk_tb_top.sv
module vstart_trap_chk_tb_top;

    localparam int VW = 16;
    localparam int EW = 3;
    localparam int CW = VW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_arith_in = 1'b1;
    logic          cfg_smove_in = 1'b1;
    logic          dec_valid = 1'b0;
    logic [2:0]    dec_class = 3'd0;
    logic [VW-1:0] vstart = '0;
    logic [CW-1:0] elem_cnt = '0;
    logic [EW-1:0] egs_log2 = '0;
    logic          trap_req;
    logic [1:0]    trap_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    vstart_trap_chk #(.VSTART_W(VW), .EGS_LOG_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_arith_in(cfg_arith_in),
        .cfg_smove_in(cfg_smove_in), .dec_valid(dec_valid), .dec_class(dec_class),
        .vstart(vstart), .elem_cnt(elem_cnt), .egs_log2(egs_log2),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    typedef struct packed {
        logic [2:0]  cls;
        logic [15:0] vs;
        logic [16:0] cnt;
        logic [2:0]  egs;
        logic [1:0]  code;
    } vec_t;

    // Both enable bits at their reset value of 1 for the whole table.
    localparam vec_t TBL [16] = '{
        '{3'd0, 16'd3,  17'd32, 3'd0, 2'b01},  // R4 arithmetic default traps
        '{3'd0, 16'd0,  17'd32, 3'd0, 2'b00},  // R2 zero start
        '{3'd1, 16'd5,  17'd32, 3'd0, 2'b00},  // R3 memory no policy
        '{3'd1, 16'd40, 17'd32, 3'd0, 2'b10},  // R9 memory past count
        '{3'd2, 16'd1,  17'd32, 3'd0, 2'b01},  // R5 scalar move default
        '{3'd3, 16'd7,  17'd32, 3'd0, 2'b01},  // R6 always class
        '{3'd4, 16'd4,  17'd32, 3'd2, 2'b00},  // R7 aligned group
        '{3'd4, 16'd6,  17'd32, 3'd2, 2'b11},  // R8 misaligned group
        '{3'd4, 16'd6,  17'd4,  3'd2, 2'b11},  // R10 align beats bounds
        '{3'd3, 16'd32, 17'd32, 3'd0, 2'b10},  // R10 bounds beats policy, equal edge
        '{3'd3, 16'd31, 17'd32, 3'd0, 2'b01},  // R9 last legal index
        '{3'd0, 16'd0,  17'd0,  3'd3, 2'b00},  // R2 zero start with zero count
        '{3'd6, 16'd2,  17'd32, 3'd0, 2'b01},  // R6 reserved code
        '{3'd0, 16'd20, 17'd64, 3'd0, 2'b01},  // R9 grouped count, not single reg
        '{3'd4, 16'd8,  17'd64, 3'd3, 2'b00},  // R8 aligned at group of 8
        '{3'd0, 16'd3,  17'd32, 3'd1, 2'b11}   // R8 odd index, pairs
    };

    task automatic check(input string req, input logic [1:0] exp_code);
        checks++;
        if (trap_code !== exp_code || trap_req !== (exp_code != 2'b00)) begin
            errors++;
            $display("FAIL %s: trap_code=%b trap_req=%b expected code=%b req=%b",
                     req, trap_code, trap_req, exp_code, (exp_code != 2'b00));
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] c, input int vs,
                         input int cnt, input int egs);
        @(negedge clk);
        dec_valid = v;
        dec_class = c;
        vstart    = VW'(vs);
        elem_cnt  = CW'(cnt);
        egs_log2  = EW'(egs);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state / idle
        drive(1'b0, 3'd3, 9, 4, 0);
        check("R11 idle after reset", 2'b00);

        for (int i = 0; i < 16; i++) begin
            drive(1'b1, TBL[i].cls, int'(TBL[i].vs), int'(TBL[i].cnt), int'(TBL[i].egs));
            check($sformatf("R1 table row %0d", i), TBL[i].code);
        end

        // R4 write in the same cycle as an arithmetic decode: old bit rules now
        drive(1'b1, 3'd0, 3, 32, 0);
        cfg_we = 1'b1; cfg_arith_in = 1'b0; cfg_smove_in = 1'b0;
        check("R4 old enable before write edge", 2'b01);
        drive(1'b1, 3'd0, 3, 32, 0);
        cfg_we = 1'b0;
        check("R4 arithmetic disabled", 2'b00);
        drive(1'b1, 3'd2, 1, 32, 0);
        check("R5 scalar move disabled", 2'b00);
        drive(1'b1, 3'd3, 1, 32, 0);
        check("R6 always class ignores enables", 2'b01);
        drive(1'b1, 3'd0, 40, 32, 0);
        check("R9 bounds independent of enable", 2'b10);

        // R5 scalar-move bit alone
        @(negedge clk);
        cfg_we = 1'b1; cfg_arith_in = 1'b0; cfg_smove_in = 1'b1;
        drive(1'b1, 3'd2, 2, 32, 0);
        cfg_we = 1'b0;
        check("R5 scalar move re-enabled", 2'b01);
        drive(1'b1, 3'd0, 2, 32, 0);
        check("R4 arithmetic still disabled", 2'b00);

        // R4/R5 reset restores both enables to 1
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        drive(1'b1, 3'd0, 2, 32, 0);
        check("R4 enable reset to 1", 2'b01);

        // R11 valid low with every trap condition present
        drive(1'b0, 3'd4, 5, 2, 2);
        check("R11 idle suppresses all", 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule